// File: doc/BRIEF.md
# Ethernet Transmit Queue with Start-Threshold Control

This block buffers outgoing frame bytes between a host that writes 16-bit words and a MAC transmit engine that reads one byte at a time. It decides when the MAC may begin a frame, which is when preamble would go out. The decision depends on a programmable byte threshold, a complete frame waiting in the queue, or a full queue, and in every case the inter-packet gap must already have expired. Toward the host it raises a data request whenever enough free space remains for a programmable number of write cycles plus one more cycle for the end-of-frame word.

While fewer than 64 bytes of the current frame have been read out, the block keeps the frame's first bytes. A retry pulse from the MAC after a collision therefore rewinds reading to the start of the frame, and the host does not write the frame again. Once 64 bytes have gone out, the retained space is handed back to the host and any later retry is ignored.

A control state machine sequences each frame. It has three states: `ST_FILL` (waiting to launch), `ST_SEND` (start-transmit high, bytes offered to the MAC) and `ST_REWIND` (one cycle after an accepted retry). It has four transitions: FILL→SEND when the launch condition holds, SEND→REWIND on an accepted retry, SEND→FILL when the last byte of the frame is read, and REWIND→FILL unconditionally.

Top module: `eth_txq`

## Requirements
- R1: After hardware reset, `tx_start` and `mac_valid` are low, and `hw_req` is high because the queue is empty.
- R2: The start code is `cfg_wdata[2:1]`, written at address 0. The codes map as 00 = 4 bytes, 01 = 16, 10 = 64 and 11 = 112, and reset selects 10. `tx_start` rises one clock after the bytes queued for the frame reach the threshold.
- R3: `tx_start` never rises while `ipg_done` is low. It rises one clock after `ipg_done` goes high if a launch condition already holds.
- R4: When a word flagged with `hw_eof` is held, the frame launches even if the threshold has not been reached.
- R5: When fewer than two bytes of space remain, the frame launches even if the threshold has not been reached.
- R6: The watermark code is `cfg_wdata[1:0]`, written at address 1. The codes map as 00 = 8 cycles, 01 = 16 and 10 = 32, and reset selects 00. `hw_req` is high exactly when the free bytes are at least 2×(cycles+1).
- R7: A new watermark code takes effect only when `cfg_wdata[2]` is set in the same write. Code 11 is reserved and leaves the watermark unchanged.
- R8: The swap bit is `cfg_wdata[0]` at address 0. When it is clear, `hw_data[7:0]` is queued first. When it is set, `hw_data[15:8]` is queued first.
- R9: A retry while `tx_start` is high and fewer than 64 bytes have been read drops `tx_start` for the next clock, and reading restarts at the first byte of the frame.
- R10: A retry after 64 or more bytes of the frame have been read is ignored, and reading continues with the next byte.
- R11: Until 64 bytes of the frame have been read, the frame's read bytes still count as occupied for `hw_req` and for space. From the 64th read on, they count as free.
- R12: Writing address 0 with `cfg_wdata[7]` set restores every configuration field to its default. The bit is self-clearing and is not stored.
- R13: `mac_last` marks the final byte of a frame. Reading that byte drops `tx_start` in the same clock, and `mac_valid` is only high while `tx_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: swap/start/soft-reset, 1: watermark/update |
| cfg_wdata | input | 8 | Configuration write data |
| hw_valid | input | 1 | Host word write |
| hw_data | input | 16 | Host word |
| hw_eof | input | 1 | Word is the last of its frame |
| hw_req | output | 1 | Host data request (watermark met) |
| ipg_done | input | 1 | Inter-packet gap has expired |
| tx_start | output | 1 | MAC may transmit the current frame |
| mac_rd | input | 1 | MAC takes the offered byte |
| mac_valid | output | 1 | A byte is offered |
| mac_data | output | 8 | Offered byte |
| mac_last | output | 1 | Offered byte ends the frame |
| retry | input | 1 | Collision retry request |

## Verification
The bench sweeps all four start codes word by word and checks the exact word on which `tx_start` rises. A threshold decode that was off by one code, or a comparison that was off by one, would launch a word early or late. It sweeps every watermark code over the whole fill range, so a request that ignored the end-of-frame reserve would stay high two bytes too long. The retry test reads across the 64-byte boundary. It checks that `hw_req` stays low through the 63rd byte and rises on the 64th, that an early retry rewinds to byte 0, and that a late retry does not rewind. A block that freed space early would corrupt retries, and one that rewound late would repeat bytes. The full-queue launch is checked on a 64-byte instance whose largest threshold cannot be reached. The byte swap and the software-reset defaults are each checked through the order of the bytes read back.

// File: rtl/eth_txq_pkg.sv
package eth_txq_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SEND   = 2'd1,
        ST_REWIND = 2'd2
    } txq_state_e;

    typedef struct packed {
        logic       swap;
        logic [1:0] start_code;
        logic [1:0] wm_code;
    } txq_cfg_t;

    localparam txq_cfg_t CFG_DEFAULT = '{swap: 1'b0, start_code: 2'b10, wm_code: 2'b00};

    function automatic int unsigned start_bytes(input logic [1:0] code);
        int unsigned n;
        unique case (code)
            2'b00:   n = 4;
            2'b01:   n = 16;
            2'b10:   n = 64;
            default: n = 112;
        endcase
        return n;
    endfunction

    function automatic int unsigned wm_cycles(input logic [1:0] code);
        int unsigned n;
        unique case (code)
            2'b01:   n = 16;
            2'b10:   n = 32;
            default: n = 8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/eth_txq_cfg.sv
module eth_txq_cfg
    import eth_txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    output txq_cfg_t   cfg
);

    logic soft_rst;

    assign soft_rst = cfg_we && !cfg_addr && cfg_wdata[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_DEFAULT;
        end else if (soft_rst) begin
            cfg <= CFG_DEFAULT;
        end else if (cfg_we) begin
            if (!cfg_addr) begin
                cfg.swap       <= cfg_wdata[0];
                cfg.start_code <= cfg_wdata[2:1];
            end else if (cfg_wdata[2] && (cfg_wdata[1:0] != 2'b11)) begin
                cfg.wm_code <= cfg_wdata[1:0];
            end
        end
    end

endmodule

// File: rtl/eth_txq_mem.sv
module eth_txq_mem #(
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [8:0]    wdata_lo,
    input  logic [8:0]    wdata_hi,
    input  logic [AW-1:0] raddr,
    output logic [8:0]    rdata
);

    logic [8:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            ram[waddr]        <= wdata_lo;
            ram[waddr + 1'b1] <= wdata_hi;
        end
    end

    assign rdata = ram[raddr];

endmodule

// File: rtl/eth_txq_ctl.sv
module eth_txq_ctl
    import eth_txq_pkg::*;
#(
    parameter  int DEPTH  = 128,
    parameter  int RETAIN = 64,
    localparam int PW     = $clog2(DEPTH) + 1,
    localparam int CW     = (PW > 8) ? PW : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  txq_cfg_t      cfg,
    input  logic          hw_valid,
    input  logic          hw_eof,
    input  logic          ipg_done,
    input  logic          mac_rd,
    input  logic          retry,
    input  logic          rd_last,
    output logic          wr_en,
    output logic [PW-2:0] wr_addr,
    output logic [PW-2:0] rd_addr,
    output logic          hw_req,
    output logic          tx_start,
    output logic          mac_valid,
    output logic [CW-1:0] free_bytes,
    output logic [CW-1:0] sent_cnt
);

    txq_state_e    state_q, state_d;
    logic [PW-1:0] wr_q, rd_q, start_q, frames_q;
    logic [CW-1:0] sent_q;
    logic [PW-1:0] rel_ptr;
    logic [CW-1:0] used, free, fill, thr, need;
    logic          avail, full, launch, retry_ok, rd_fire, rd_commit;
    logic          frame_in, frame_out;

    // occupancy and thresholds
    always_comb begin
        rel_ptr = (sent_q < CW'(RETAIN)) ? start_q : rd_q;
        used    = CW'(wr_q - rel_ptr);
        free    = CW'(DEPTH) - used;
        fill    = CW'(wr_q - start_q);
        thr     = CW'(start_bytes(cfg.start_code));
        need    = CW'(2 * (wm_cycles(cfg.wm_code) + 1));
    end

    assign avail     = (rd_q != wr_q);
    assign full      = (free < CW'(2));
    assign wr_en     = hw_valid && !full;
    assign launch    = ipg_done && ((fill >= thr) || (frames_q != '0) || full);
    assign rd_fire   = mac_valid && mac_rd;
    assign retry_ok  = (state_q == ST_SEND) && retry && (sent_q < CW'(RETAIN));
    assign rd_commit = rd_fire && !retry_ok;
    assign frame_in  = wr_en && hw_eof;
    assign frame_out = rd_commit && rd_last;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:   if (launch) state_d = ST_SEND;
            ST_SEND: begin
                if (retry_ok)       state_d = ST_REWIND;
                else if (frame_out) state_d = ST_FILL;
            end
            ST_REWIND: state_d = ST_FILL;
            default:   state_d = ST_FILL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        tx_start  = 1'b0;
        mac_valid = 1'b0;
        unique case (state_q)
            ST_FILL:   ;
            ST_SEND: begin
                tx_start  = 1'b1;
                mac_valid = avail;
            end
            ST_REWIND: ;
            default:   ;
        endcase
    end

    // pointers and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_q     <= '0;
            start_q  <= '0;
            sent_q   <= '0;
            frames_q <= '0;
        end else begin
            if (wr_en) wr_q <= wr_q + PW'(2);
            if (retry_ok) begin
                rd_q   <= start_q;
                sent_q <= '0;
            end else if (rd_commit) begin
                rd_q <= rd_q + 1'b1;
                if (rd_last) begin
                    start_q <= rd_q + 1'b1;
                    sent_q  <= '0;
                end else if (sent_q < CW'(RETAIN)) begin
                    sent_q <= sent_q + 1'b1;
                end
            end
            unique case ({frame_in, frame_out})
                2'b10:   frames_q <= frames_q + 1'b1;
                2'b01:   frames_q <= frames_q - 1'b1;
                default: frames_q <= frames_q;
            endcase
        end
    end

    assign wr_addr    = wr_q[PW-2:0];
    assign rd_addr    = rd_q[PW-2:0];
    assign hw_req     = (free >= need);
    assign free_bytes = free;
    assign sent_cnt   = sent_q;

endmodule

// File: rtl/eth_txq.sv
module eth_txq
    import eth_txq_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int RETAIN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        hw_valid,
    input  logic [15:0] hw_data,
    input  logic        hw_eof,
    output logic        hw_req,
    input  logic        ipg_done,
    output logic        tx_start,
    input  logic        mac_rd,
    output logic        mac_valid,
    output logic [7:0]  mac_data,
    output logic        mac_last,
    input  logic        retry
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int CW = (PW > 8) ? PW : 8;

    txq_cfg_t      cfg;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [8:0]    rdata;
    logic [7:0]    first_b, second_b;
    logic [CW-1:0] free_bytes, sent_cnt;

    eth_txq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg      (cfg)
    );

    assign first_b  = cfg.swap ? hw_data[15:8] : hw_data[7:0];
    assign second_b = cfg.swap ? hw_data[7:0]  : hw_data[15:8];

    eth_txq_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata_lo({1'b0, first_b}),
        .wdata_hi({hw_eof, second_b}),
        .raddr   (rd_addr),
        .rdata   (rdata)
    );

    eth_txq_ctl #(.DEPTH(DEPTH), .RETAIN(RETAIN)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .hw_valid  (hw_valid),
        .hw_eof    (hw_eof),
        .ipg_done  (ipg_done),
        .mac_rd    (mac_rd),
        .retry     (retry),
        .rd_last   (rdata[8]),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .hw_req    (hw_req),
        .tx_start  (tx_start),
        .mac_valid (mac_valid),
        .free_bytes(free_bytes),
        .sent_cnt  (sent_cnt)
    );

    assign mac_data = rdata[7:0];
    assign mac_last = rdata[8];

endmodule

// File: rtl/eth_txq_chk.sv
module eth_txq_chk #(
    parameter  int DEPTH  = 128,
    parameter  int RETAIN = 64,
    localparam int PW     = $clog2(DEPTH) + 1,
    localparam int CW     = (PW > 8) ? PW : 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ipg_done,
    input logic          tx_start,
    input logic          retry,
    input logic          mac_valid,
    input logic          mac_rd,
    input logic          mac_last,
    input logic          hw_req,
    input logic [CW-1:0] free_bytes,
    input logic [CW-1:0] sent_cnt
);

    p_launch_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start) |-> $past(ipg_done));

    p_valid_in_send_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> tx_start);

    p_req_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |-> (free_bytes >= CW'(18)));

    p_retry_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && retry && (sent_cnt < CW'(RETAIN))) |=> !tx_start);

    p_retry_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && retry && (sent_cnt >= CW'(RETAIN)) && !(mac_valid && mac_rd && mac_last))
        |=> tx_start);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        free_bytes <= CW'(DEPTH));

endmodule

bind eth_txq eth_txq_chk #(.DEPTH(DEPTH), .RETAIN(RETAIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ipg_done  (ipg_done),
    .tx_start  (tx_start),
    .retry     (retry),
    .mac_valid (mac_valid),
    .mac_rd    (mac_rd),
    .mac_last  (mac_last),
    .hw_req    (hw_req),
    .free_bytes(free_bytes),
    .sent_cnt  (sent_cnt)
);

// File: tb/eth_txq_test.sv
`timescale 1ns/1ps
module eth_txq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        hw_valid = 1'b0, hw_eof = 1'b0;
    logic [15:0] hw_data = '0;
    logic        ipg_done = 1'b0, mac_rd = 1'b0, retry = 1'b0;
    logic        hw_req, tx_start, mac_valid, mac_last;
    logic [7:0]  mac_data;
    logic        s_hw_req, s_tx_start, s_mac_valid, s_mac_last;
    logic [7:0]  s_mac_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eth_txq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hw_valid(hw_valid), .hw_data(hw_data), .hw_eof(hw_eof), .hw_req(hw_req),
        .ipg_done(ipg_done), .tx_start(tx_start), .mac_rd(mac_rd), .mac_valid(mac_valid),
        .mac_data(mac_data), .mac_last(mac_last), .retry(retry)
    );

    eth_txq #(.DEPTH(64), .RETAIN(64)) uut_small (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hw_valid(hw_valid), .hw_data(hw_data), .hw_eof(hw_eof), .hw_req(s_hw_req),
        .ipg_done(ipg_done), .tx_start(s_tx_start), .mac_rd(mac_rd), .mac_valid(s_mac_valid),
        .mac_data(s_mac_data), .mac_last(s_mac_last), .retry(retry)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ipg_done = 1'b0; mac_rd = 1'b0; retry = 1'b0;
        hw_valid = 1'b0; cfg_we = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] d, input logic eof);
        hw_valid = 1'b1; hw_data = d; hw_eof = eof;
        tick();
        hw_valid = 1'b0; hw_eof = 1'b0;
    endtask

    function automatic logic [15:0] word_of(input int k);
        return {8'(2 * k + 1), 8'(2 * k)};
    endfunction

    task automatic read_byte(output logic [8:0] b);
        int wait_n = 0;
        while (!mac_valid && wait_n < 1000) begin
            tick();
            wait_n++;
        end
        b = {mac_last, mac_data};
        mac_rd = 1'b1;
        tick();
        mac_rd = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] b;
        int thr_tab[4];
        int wm_tab[3];
        thr_tab = '{4, 16, 64, 112};
        wm_tab  = '{8, 16, 32};

        // R1 reset state
        do_reset();
        chk("R1 tx_start", int'(tx_start), 0);
        chk("R1 mac_valid", int'(mac_valid), 0);
        chk("R1 hw_req", int'(hw_req), 1);

        // R2 start threshold sweep (code 10 left at its reset default)
        for (int c = 0; c < 4; c++) begin
            do_reset();
            if (c != 2) cfg_write(1'b0, {5'b0, 2'(c), 1'b0});
            ipg_done = 1'b1;
            for (int k = 1; k <= 56; k++) begin
                push(word_of(k), 1'b0);
                tick();
                chk("R2 threshold launch", int'(tx_start), (2 * k >= thr_tab[c]) ? 1 : 0);
            end
        end

        // R3 gap gating
        do_reset();
        cfg_write(1'b0, 8'h00);
        for (int k = 0; k < 20; k++) push(word_of(k), 1'b0);
        tick();
        chk("R3 held without gap", int'(tx_start), 0);
        ipg_done = 1'b1;
        tick();
        chk("R3 launch after gap", int'(tx_start), 1);

        // R4 complete frame launches below threshold; R13 last marker
        do_reset();
        cfg_write(1'b0, 8'h06);
        ipg_done = 1'b1;
        push(word_of(0), 1'b0);
        push(word_of(1), 1'b0);
        tick();
        chk("R4 no launch yet", int'(tx_start), 0);
        push(word_of(2), 1'b1);
        tick();
        chk("R4 eof launch", int'(tx_start), 1);
        for (int i = 0; i < 6; i++) begin
            read_byte(b);
            chk("R4 data", int'(b[7:0]), i);
            chk("R13 last flag", int'(b[8]), (i == 5) ? 1 : 0);
        end
        chk("R13 tx_start drops", int'(tx_start), 0);
        chk("R13 valid drops", int'(mac_valid), 0);

        // R5 full queue launches (64-byte instance, threshold 112)
        do_reset();
        cfg_write(1'b0, 8'h06);
        ipg_done = 1'b1;
        for (int k = 1; k <= 32; k++) begin
            push(word_of(k), 1'b0);
            tick();
            chk("R5 full launch", int'(s_tx_start), (k == 32) ? 1 : 0);
        end
        chk("R5 large not launched", int'(tx_start), 0);

        // R6 watermark sweep
        for (int c = 0; c < 3; c++) begin
            do_reset();
            if (c != 0) cfg_write(1'b1, {5'b0, 1'b1, 2'(c)});
            for (int k = 1; k <= 64; k++) begin
                push(word_of(k), 1'b0);
                chk("R6 request", int'(hw_req), ((128 - 2 * k) >= 2 * (wm_tab[c] + 1)) ? 1 : 0);
            end
        end

        // R7 update bit and reserved code
        do_reset();
        for (int k = 0; k < 50; k++) push(word_of(k), 1'b0);
        cfg_write(1'b1, 8'h02);
        chk("R7 no update bit", int'(hw_req), 1);
        cfg_write(1'b1, 8'h07);
        chk("R7 reserved code", int'(hw_req), 1);
        cfg_write(1'b1, 8'h06);
        chk("R7 updated", int'(hw_req), 0);

        // R8 byte swap
        do_reset();
        cfg_write(1'b0, 8'h01);
        ipg_done = 1'b1;
        push(16'hA1B2, 1'b1);
        read_byte(b);
        chk("R8 swapped first", int'(b[7:0]), 8'hA1);
        read_byte(b);
        chk("R8 swapped second", int'(b[7:0]), 8'hB2);
        cfg_write(1'b0, 8'h00);
        push(16'hA1B2, 1'b1);
        read_byte(b);
        chk("R8 plain first", int'(b[7:0]), 8'hB2);
        read_byte(b);
        chk("R8 plain second", int'(b[7:0]), 8'hA1);

        // R9 R10 R11 retry and retention
        do_reset();
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h06);
        for (int k = 0; k < 40; k++) push(word_of(k), (k == 39) ? 1'b1 : 1'b0);
        chk("R11 retained full", int'(hw_req), 0);
        ipg_done = 1'b1;
        for (int i = 0; i < 10; i++) begin
            read_byte(b);
            chk("R9 pre-retry data", int'(b[7:0]), i);
        end
        chk("R11 space held", int'(hw_req), 0);
        retry = 1'b1;
        tick();
        retry = 1'b0;
        chk("R9 tx_start drops", int'(tx_start), 0);
        for (int i = 0; i < 70; i++) begin
            read_byte(b);
            chk("R9 replay data", int'(b[7:0]), i);
            if (i == 62) chk("R11 held at 63", int'(hw_req), 0);
            if (i == 63) chk("R11 released at 64", int'(hw_req), 1);
        end
        retry = 1'b1;
        tick();
        retry = 1'b0;
        chk("R10 retry ignored", int'(tx_start), 1);
        for (int i = 70; i < 80; i++) begin
            read_byte(b);
            chk("R10 continue data", int'(b[7:0]), i);
            chk("R13 last flag", int'(b[8]), (i == 79) ? 1 : 0);
        end
        chk("R13 frame ends", int'(tx_start), 0);

        // R12 software reset restores defaults
        do_reset();
        cfg_write(1'b0, 8'h01);
        cfg_write(1'b1, 8'h06);
        cfg_write(1'b0, 8'h80);
        ipg_done = 1'b1;
        push(word_of(0), 1'b0);
        push(word_of(1), 1'b0);
        tick();
        chk("R12 threshold default", int'(tx_start), 0);
        push(16'hA1B2, 1'b1);
        tick();
        chk("R12 eof launch", int'(tx_start), 1);
        for (int i = 0; i < 4; i++) begin
            read_byte(b);
            chk("R12 data", int'(b[7:0]), i);
        end
        read_byte(b);
        chk("R12 swap default", int'(b[7:0]), 8'hB2);
        read_byte(b);
        chk("R12 swap default hi", int'(b[7:0]), 8'hA1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule